// File: doc/BRIEF.md
# Reference clock buffer re-enable sequencer

This block brings a transceiver PLL reference clock input back into service after the clock was absent while the device was being configured. Once a start request confirms the clock is running again, the sequencer issues a single byte-wide write on a simple memory-mapped register port. That write sets the enable bit for the chosen buffer. The sequencer then reads the buffer acknowledge field once per 100 microsecond interval until the chosen bit reads zero. At that point it raises a sticky reference-clock-ready output.

After ready is raised, the sequencer keeps reading the same field at the same interval. If the chosen bit ever reads one, the buffer has switched off and a sticky lost flag is set. When a bypass input says the clock was already present at configuration, ready is raised at once and no register traffic is issued. If the acknowledge bit is still set after a limited number of polls, the sequencer stops in an error state.

Top module: `refclk_buf_sequencer`

## Requirements
- R1: With `bypass` high in the idle state, `refclk_ready` is high from the next cycle onward, and no read or write is ever issued.
- R2: After `start`, exactly one write is issued. It targets address 0x000A6038, has byte enables 4'b0100, and its data has a single 1 at bit position 16+`sel`. The write is held stable until `m_waitreq` is low.
- R3: The first read is issued CLK_MHZ*100+1 cycles after the cycle in which the write is accepted. Every later read is issued CLK_MHZ*100+1 cycles after the previous `m_rdvalid` cycle.
- R4: A read response is judged only on bit 8+`sel` of `m_rdata`. All other acknowledge bits have no effect on `refclk_ready` or `buf_lost`.
- R5: `refclk_ready` rises in the cycle after an `m_rdvalid` whose selected bit is 0. It never rises before the write.
- R6: If MAX_POLLS responses in a row have the selected bit set, `seq_error` goes high, `refclk_ready` stays low, and no further bus traffic occurs.
- R7: Once ready, polling continues at the same interval. A response with the selected bit at 1 sets `buf_lost`, which stays set until reset, while `refclk_ready` stays high.
- R8: `refclk_ready` stays high until reset. Reset clears `refclk_ready`, `buf_lost`, `seq_error` and both bus strobes.
- R9: `sel` is captured when `start` is accepted. Later changes to `sel` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to run the re-enable sequence |
| bypass | input | 1 | Clock was present at configuration; skip the sequence |
| sel | input | 3 | Index of the buffer to service |
| m_addr | output | 32 | Register port address |
| m_write | output | 1 | Write strobe |
| m_read | output | 1 | Read strobe |
| m_wdata | output | 32 | Write data |
| m_byteen | output | 4 | Byte enables |
| m_waitreq | input | 1 | Slave stall; the strobe is held while high |
| m_rdata | input | 32 | Read data |
| m_rdvalid | input | 1 | Read data valid pulse |
| refclk_ready | output | 1 | Reference clock ready, sticky |
| buf_lost | output | 1 | Sticky flag: buffer found switched off after ready |
| seq_error | output | 1 | Poll limit exceeded |

## Verification
The in-line properties check the following on every cycle:
- the two strobes are never high together, and each command is held while stalled;
- the write's lane and data shape are correct;
- ready and lost are sticky, and error and ready are mutually exclusive;
- ready rises only after a bypass or after a clear acknowledge response.

Some behaviours only the bench scenarios can show:
- the exact poll interval in cycles;
- the number of reads before ready or error;
- that other acknowledge bits and later changes to `sel` are ignored;
- that bypass produces no traffic at all.

// File: rtl/refclk_buf_sequencer.sv
module refclk_buf_sequencer #(
  parameter int          CLK_MHZ   = 100,
  parameter int          MAX_POLLS = 64,
  parameter logic [31:0] REG_ADDR  = 32'h000A_6038
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        bypass,
  input  logic [2:0]  sel,
  output logic [31:0] m_addr,
  output logic        m_write,
  output logic        m_read,
  output logic [31:0] m_wdata,
  output logic [3:0]  m_byteen,
  input  logic        m_waitreq,
  input  logic [31:0] m_rdata,
  input  logic        m_rdvalid,
  output logic        refclk_ready,
  output logic        buf_lost,
  output logic        seq_error
);
  localparam int TICKS = CLK_MHZ * 100;
  localparam int TW    = $clog2(TICKS + 1);
  localparam int PW    = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {S_IDLE, S_BYP, S_WR, S_WAIT, S_RD, S_RDW, S_ERR} state_t;
  state_t          state;
  logic [2:0]      sel_q;
  logic [TW-1:0]   tmr;
  logic [PW-1:0]   polls;

  wire ack_bit = m_rdata[8 + sel_q];

  assign m_addr   = REG_ADDR;
  assign m_write  = (state == S_WR);
  assign m_read   = (state == S_RD);
  assign m_wdata  = 32'h1 << (16 + sel_q);
  assign m_byteen = m_write ? 4'b0100 : 4'b1111;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      sel_q        <= '0;
      tmr          <= '0;
      polls        <= '0;
      refclk_ready <= 1'b0;
      buf_lost     <= 1'b0;
      seq_error    <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (bypass) begin
            state        <= S_BYP;
            refclk_ready <= 1'b1;
          end else if (start) begin
            state <= S_WR;
            sel_q <= sel;
          end
        S_WR:
          if (!m_waitreq) begin
            state <= S_WAIT;
            tmr   <= TW'(TICKS - 1);
          end
        S_WAIT:
          if (tmr == '0) state <= S_RD;
          else           tmr   <= tmr - 1'b1;
        S_RD:
          if (!m_waitreq) state <= S_RDW;
        S_RDW:
          if (m_rdvalid) begin
            tmr <= TW'(TICKS - 1);
            if (refclk_ready) begin
              if (ack_bit) buf_lost <= 1'b1;
              state <= S_WAIT;
            end else if (!ack_bit) begin
              refclk_ready <= 1'b1;
              state        <= S_WAIT;
            end else if (polls == PW'(MAX_POLLS - 1)) begin
              seq_error <= 1'b1;
              state     <= S_ERR;
            end else begin
              polls <= polls + 1'b1;
              state <= S_WAIT;
            end
          end
        default: ;
      endcase
    end
  end

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_read && m_write));
  assert_write_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_write |-> (m_byteen == 4'b0100) && $onehot0(m_wdata) && (m_wdata[23:16] != 8'h00));
  assert_write_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_write && m_waitreq |=> m_write && $stable(m_wdata));
  assert_read_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_read && m_waitreq |=> m_read);
  assert_ready_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refclk_ready) |-> $past(bypass) || ($past(m_rdvalid) && !$past(ack_bit)));
  assert_error_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_error |-> !refclk_ready && !m_read && !m_write);
  assert_lost_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_lost |=> buf_lost && refclk_ready);
  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refclk_ready |=> refclk_ready);
  assert_bypass_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BYP) |-> !m_read && !m_write);
endmodule

// File: tb/refclk_buf_sequencer_tb.sv
module refclk_buf_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 1;
  localparam int MAX_POLLS  = 4;
  localparam int TICKS      = CLK_MHZ * 100;
  localparam logic [31:0] ADDR = 32'h000A_6038;

  // vector: {sel, busy reads before clear, expect ready}
  localparam logic [6:0] VEC [5] = '{
    {3'd0, 3'd0, 1'b1}, {3'd3, 3'd2, 1'b1}, {3'd7, 3'd3, 1'b1},
    {3'd5, 3'd4, 1'b0}, {3'd1, 3'd6, 1'b0}};

  logic clk = 0, rst_n = 0, start = 0, bypass = 0;
  logic [2:0] sel = 0;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic m_write, m_read, m_waitreq, m_rdvalid;
  logic [3:0] m_byteen;
  logic refclk_ready, buf_lost, seq_error;

  int checks = 0, fails = 0;
  int cyc = 0;
  logic clr = 0, lost_mode = 0;
  logic [2:0] sel_ref = 0;
  int busy_init = 0;
  int busy, wcnt, nwr, nrd, t_wacc, t_rd1, t_rdv, t_rdy;
  logic [31:0] w_data, w_addr;
  logic [3:0] w_be;
  logic [7:0] ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  refclk_buf_sequencer #(.CLK_MHZ(CLK_MHZ), .MAX_POLLS(MAX_POLLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bypass(bypass), .sel(sel),
    .m_addr(m_addr), .m_write(m_write), .m_read(m_read), .m_wdata(m_wdata),
    .m_byteen(m_byteen), .m_waitreq(m_waitreq), .m_rdata(m_rdata),
    .m_rdvalid(m_rdvalid), .refclk_ready(refclk_ready), .buf_lost(buf_lost),
    .seq_error(seq_error));

  assign m_waitreq = (m_write || m_read) && (wcnt != 2);
  assign ack = (lost_mode || busy > 0) ? 8'hFF : ~(8'h01 << sel_ref);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) begin
      wcnt <= 0; nwr <= 0; nrd <= 0; t_wacc <= -1; t_rd1 <= -1; t_rdv <= -1;
      t_rdy <= -1; busy <= busy_init; m_rdvalid <= 0; m_rdata <= 0;
      w_data <= 0; w_addr <= 0; w_be <= 0;
    end else begin
      m_rdvalid <= 0;
      if (m_rdvalid) t_rdv <= cyc;
      if (refclk_ready && t_rdy < 0) t_rdy <= cyc;
      if (m_read && wcnt == 0 && t_rd1 < 0) t_rd1 <= cyc;
      if (m_write || m_read) begin
        wcnt <= (wcnt == 2) ? 0 : wcnt + 1;
        if (wcnt == 2 && m_write) begin
          nwr <= nwr + 1; w_data <= m_wdata; w_addr <= m_addr; w_be <= m_byteen;
          t_wacc <= cyc;
        end
        if (wcnt == 2 && m_read) begin
          nrd <= nrd + 1; m_rdvalid <= 1; m_rdata <= {16'h0, ack, 8'h00};
          if (busy > 0) busy <= busy - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(input logic [2:0] s, input int b, input logic byp);
    @(negedge clk);
    rst_n = 0; clr = 1; busy_init = b; sel_ref = s; sel = s; bypass = byp;
    lost_mode = 0; start = 0;
    repeat (3) @(negedge clk);
    clr = 0; rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_to_end();
    start = 1;
    @(negedge clk);
    start = 0; sel = ~sel_ref;
    for (int i = 0; i < 20 * TICKS && !refclk_ready && !seq_error; i++) @(negedge clk);
  endtask

  initial begin
    restart(3'd0, 0, 0);
    rst_n = 0;
    @(negedge clk);
    chk(!refclk_ready && !buf_lost && !seq_error && !m_read && !m_write,
        "R8 reset state", {refclk_ready, buf_lost, seq_error, m_read, m_write}, 0);
    rst_n = 1;

    foreach (VEC[v]) begin
      logic [2:0] s;
      int b, er;
      logic exp_rdy;
      s = VEC[v][6:4]; b = VEC[v][3:1]; exp_rdy = VEC[v][0];
      er = exp_rdy ? b + 1 : MAX_POLLS;
      restart(s, b, 0);
      run_to_end();
      @(negedge clk);
      chk(refclk_ready == exp_rdy, "R5/R6 ready outcome", refclk_ready, exp_rdy);
      chk(seq_error == !exp_rdy, "R6 error outcome", seq_error, !exp_rdy);
      chk(nwr == 1, "R2 write count", nwr, 1);
      chk(w_data == (32'h1 << (16 + s)), "R2/R9 write data", w_data, 32'h1 << (16 + s));
      chk(w_be == 4'b0100, "R2 byte enables", w_be, 4'b0100);
      chk(w_addr == ADDR, "R2 address", w_addr, ADDR);
      chk(t_rd1 - t_wacc == TICKS + 1, "R3 first poll delay", t_rd1 - t_wacc, TICKS + 1);
      if (exp_rdy) begin
        chk(nrd == er, "R4 reads before ready", nrd, er);
        chk(t_rdy == t_rdv + 1, "R5 ready timing", t_rdy, t_rdv + 1);
      end else begin
        repeat (3 * TICKS) @(negedge clk);
        chk(nrd == er, "R6 reads then silence", nrd, er);
        chk(!refclk_ready, "R6 ready stays low", refclk_ready, 0);
      end
    end

    // monitoring after ready
    restart(3'd2, 1, 0);
    run_to_end();
    repeat (2 * TICKS + 20) @(negedge clk);
    chk(nrd == 4, "R7 polling continues", nrd, 4);
    chk(t_rdv >= 0 && !buf_lost, "R4 other ack bits ignored", buf_lost, 0);
    lost_mode = 1;
    repeat (TICKS + 10) @(negedge clk);
    chk(buf_lost, "R7 lost flagged", buf_lost, 1);
    chk(refclk_ready, "R7 ready kept", refclk_ready, 1);
    lost_mode = 0;
    repeat (2 * TICKS + 10) @(negedge clk);
    chk(buf_lost && refclk_ready, "R8 flags sticky", {buf_lost, refclk_ready}, 3);

    // bypass
    restart(3'd4, 0, 1);
    chk(refclk_ready, "R1 bypass ready", refclk_ready, 1);
    start = 1;
    @(negedge clk);
    start = 0; bypass = 0;
    repeat (3 * TICKS) @(negedge clk);
    chk(nwr == 0 && nrd == 0, "R1 no bus traffic", nwr + nrd, 0);
    chk(refclk_ready, "R8 bypass ready holds", refclk_ready, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule